// File: doc/BRIEF.md
# Dual-Mode Host Bus Channel Decoder

This block is the host-facing register bus front end of a four-channel peripheral. A static mode input picks one of two processor bus styles that share the same pins. In split-strobe mode the host has separate active-low read and write strobes and four active-low chip selects, one per channel. In single-select mode one chip select frames each cycle, the write-strobe pin carries a read/write direction level, and two of the spare chip-select pins become channel address bits.

All host inputs are asynchronous to the system clock. They pass through a two-flop synchronizer, and edges are detected on the synchronized copies. The decoded access goes to the channels as a one-hot channel select, a 3-bit register address and a single-cycle read or write pulse. Write data is captured from the host data bus. Read data is taken from the selected channel's byte and returned on the host data bus. That bus is modelled as separate in and out buses with an output enable.

Top module: `dual_bus_decoder`

## Requirements
- R1: After reset the read pulse, write pulse and data output enable are all 0.
- R2: With splitMode=1, a falling read strobe while a chip select is low gives one read pulse on the channel of that select (csN bit i is channel i), with regAddr equal to addr. hostDataOe is then 1 and hostDataOut carries that channel's byte.
- R3: With splitMode=1, a rising write strobe while a chip select is low gives one write pulse to that channel, carrying addr and the synchronized host data byte.
- R4: With splitMode=1 and several chip selects low, the lowest-numbered channel is served.
- R5: With splitMode=1 and no chip select low, strobes produce no pulse and hostDataOe stays 0.
- R6: With splitMode=0, a falling csN[0] while wrN is 1 starts a read. The channel number is {csN[2], csN[1]}, with csN[1] as the low bit.
- R7: With splitMode=0, a rising csN[0] commits a write if wrN was 0 at that time, to the channel {csN[2], csN[1]}.
- R8: With splitMode=0, the rdN pin and csN[3] have no effect on pulses, channel choice or the output enable.
- R9: hostDataOe goes to 0 by the third clock edge after the read strobe (split mode) or csN[0] (single mode) returns high.
- R10: A read access gives exactly one read pulse, however long the strobe is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| splitMode | input | 1 | 1: split-strobe bus, 0: single-select bus (static) |
| rdN | input | 1 | Read strobe, active low (split mode only) |
| wrN | input | 1 | Write strobe (split) or read=1/write=0 level (single) |
| csN | input | 4 | Per-channel selects (split); [0] select, [1] ch bit0, [2] ch bit1 (single) |
| addr | input | 3 | Register address within the channel |
| hostDataIn | input | 8 | Data driven by the host |
| hostDataOut | output | 8 | Data returned to the host |
| hostDataOe | output | 1 | Output enable for hostDataOut |
| chSel | output | 4 | One-hot channel select qualifying the pulses |
| regAddr | output | 3 | Register address for the channel |
| rdPulse | output | 1 | Single-cycle read pulse |
| wrPulse | output | 1 | Single-cycle write pulse |
| wrData | output | 8 | Byte to write |
| chRdData | input | 32 | Read bytes of all channels, channel i at bits 8i+7:8i |

## Verification
The bench builds the block with its defaults: four channels, eight registers each and byte data. That small space allows a full sweep, in both bus modes, of every channel and register address for both reads and writes. It also covers all fifteen non-empty chip-select combinations for priority. Expected channel indices and register bytes are worked out arithmetically from the sweep indices. The single-mode sweep toggles csN[3] with the address and also drives read strobes with the device deselected.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int HB_CHANNELS = 4;
  localparam int HB_CH_W = $clog2(HB_CHANNELS);

  typedef struct packed {
    logic               rdStart;
    logic               wrCommit;
    logic               rdHold;
    logic               chValid;
    logic [HB_CH_W-1:0] ch;
  } ctlStrobe_t;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int WIDTH = 8,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stage[s] <= RESET_VAL;
      else if (s == 0) stage[s] <= asyncIn;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/hbus_ctl.sv
module hbus_ctl
  import hbus_pkg::*;
#(
  parameter int NUM_CH = HB_CHANNELS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              splitMode,
  input  logic              rdS,
  input  logic              wrS,
  input  logic [NUM_CH-1:0] csS,
  output ctlStrobe_t        strobe
);
  localparam int CH_W = $clog2(NUM_CH);

  logic rdP, wrP, cs0P;
  logic [CH_W-1:0] prioCh;
  logic prioValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdP  <= 1'b1;
      wrP  <= 1'b1;
      cs0P <= 1'b1;
    end else begin
      rdP  <= rdS;
      wrP  <= wrS;
      cs0P <= csS[0];
    end
  end

  // Lowest-numbered active select wins: scan downward so it is taken last.
  always_comb begin
    prioCh = '0;
    prioValid = 1'b0;
    for (int i = NUM_CH-1; i >= 0; i--) begin
      if (!csS[i]) begin
        prioCh = CH_W'(i);
        prioValid = 1'b1;
      end
    end
  end

  always_comb begin
    strobe = '0;
    if (splitMode) begin
      strobe.ch       = prioCh;
      strobe.chValid  = prioValid;
      strobe.rdStart  = prioValid && !rdS && rdP;
      strobe.wrCommit = prioValid && wrS && !wrP;
      strobe.rdHold   = prioValid && !rdS;
    end else begin
      strobe.ch       = csS[CH_W:1];
      strobe.chValid  = 1'b1;
      strobe.rdStart  = !csS[0] && cs0P && wrS;
      strobe.wrCommit = csS[0] && !cs0P && !wrP;
      strobe.rdHold   = !csS[0];
    end
  end

  a_r5_start_needs_select: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdStart || strobe.wrCommit) |-> strobe.chValid);
  a_r10_no_back_to_back_start: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdStart |=> !strobe.rdStart);
endmodule

// File: rtl/hbus_datapath.sv
module hbus_datapath
  import hbus_pkg::*;
#(
  parameter int NUM_CH = HB_CHANNELS,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctlStrobe_t               strobe,
  input  logic [ADDR_W-1:0]        addrS,
  input  logic [DATA_W-1:0]        dataS,
  input  logic [NUM_CH*DATA_W-1:0] chRdData,
  output logic [NUM_CH-1:0]        chSel,
  output logic [ADDR_W-1:0]        regAddr,
  output logic                     rdPulse,
  output logic                     wrPulse,
  output logic [DATA_W-1:0]        wrData,
  output logic [DATA_W-1:0]        rdByte,
  output logic                     dataOe
);
  localparam int CH_W = $clog2(NUM_CH);

  logic [CH_W-1:0] chIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chIdx   <= '0;
      regAddr <= '0;
      wrData  <= '0;
      rdPulse <= 1'b0;
      wrPulse <= 1'b0;
      dataOe  <= 1'b0;
    end else begin
      rdPulse <= strobe.rdStart;
      wrPulse <= strobe.wrCommit && !strobe.rdStart;
      dataOe  <= strobe.rdStart || (dataOe && strobe.rdHold);
      if (strobe.rdStart || strobe.wrCommit) begin
        chIdx   <= strobe.ch;
        regAddr <= addrS;
      end
      if (strobe.wrCommit) wrData <= dataS;
    end
  end

  always_comb begin
    chSel = '0;
    chSel[chIdx] = 1'b1;
  end

  assign rdByte = chRdData[chIdx*DATA_W +: DATA_W];

  a_r3_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(rdPulse && wrPulse));
  a_r2_oe_with_read: assert property (@(posedge clk) disable iff (!rstN)
    rdPulse |-> dataOe);
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdPulse |=> !rdPulse);
  a_r2_oe_rises_on_read: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> rdPulse);
  a_r4_sel_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(chSel));
endmodule

// File: rtl/dual_bus_decoder.sv
module dual_bus_decoder
  import hbus_pkg::*;
#(
  parameter int NUM_CH = HB_CHANNELS,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     splitMode,
  input  logic                     rdN,
  input  logic                     wrN,
  input  logic [NUM_CH-1:0]        csN,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        hostDataIn,
  output logic [DATA_W-1:0]        hostDataOut,
  output logic                     hostDataOe,
  output logic [NUM_CH-1:0]        chSel,
  output logic [ADDR_W-1:0]        regAddr,
  output logic                     rdPulse,
  output logic                     wrPulse,
  output logic [DATA_W-1:0]        wrData,
  input  logic [NUM_CH*DATA_W-1:0] chRdData
);
  localparam int SYNC_W = 2 + NUM_CH + ADDR_W + DATA_W;
  localparam logic [SYNC_W-1:0] SYNC_RST = {{(2+NUM_CH){1'b1}}, {(ADDR_W+DATA_W){1'b0}}};

  logic [SYNC_W-1:0] syncVec;
  logic rdS, wrS;
  logic [NUM_CH-1:0] csS;
  logic [ADDR_W-1:0] addrS;
  logic [DATA_W-1:0] dataS;
  logic [DATA_W-1:0] rdByte;
  ctlStrobe_t strobe;

  hbus_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RESET_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({rdN, wrN, csN, addr, hostDataIn}),
    .syncOut(syncVec)
  );

  assign {rdS, wrS, csS, addrS, dataS} = syncVec;

  hbus_ctl #(.NUM_CH(NUM_CH)) u_ctl (
    .clk(clk), .rstN(rstN), .splitMode(splitMode),
    .rdS(rdS), .wrS(wrS), .csS(csS), .strobe(strobe)
  );

  hbus_datapath #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addrS(addrS), .dataS(dataS),
    .chRdData(chRdData), .chSel(chSel), .regAddr(regAddr),
    .rdPulse(rdPulse), .wrPulse(wrPulse), .wrData(wrData),
    .rdByte(rdByte), .dataOe(hostDataOe)
  );

  assign hostDataOut = hostDataOe ? rdByte : '0;
endmodule

// File: tb/test_dual_bus_decoder.sv
`timescale 1ns/1ps
module test_dual_bus_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic splitMode = 1'b1;
  logic rdN = 1'b1, wrN = 1'b1;
  logic [3:0] csN = 4'hF;
  logic [2:0] addr = '0;
  logic [7:0] hostDataIn = '0;
  logic [7:0] hostDataOut, wrData;
  logic hostDataOe, rdPulse, wrPulse;
  logic [3:0] chSel;
  logic [2:0] regAddr;
  logic [31:0] chRdData;
  logic [7:0] mem [4][8];

  int errors = 0, checks = 0;
  int rdCnt = 0, wrCnt = 0;
  logic [3:0] lastRdSel, lastWrSel;
  logic [2:0] lastRdAddr;

  always #2.5 clk = ~clk;

  dual_bus_decoder i_dual_bus_decoder (
    .clk(clk), .rstN(rstN), .splitMode(splitMode), .rdN(rdN), .wrN(wrN),
    .csN(csN), .addr(addr), .hostDataIn(hostDataIn), .hostDataOut(hostDataOut),
    .hostDataOe(hostDataOe), .chSel(chSel), .regAddr(regAddr),
    .rdPulse(rdPulse), .wrPulse(wrPulse), .wrData(wrData), .chRdData(chRdData)
  );

  always_comb
    for (int c = 0; c < 4; c++) chRdData[c*8 +: 8] = mem[c][regAddr];

  always @(negedge clk) begin
    if (rdPulse) begin
      rdCnt++;
      lastRdSel = chSel;
      lastRdAddr = regAddr;
    end
    if (wrPulse) begin
      wrCnt++;
      lastWrSel = chSel;
      for (int c = 0; c < 4; c++) if (chSel[c]) mem[c][regAddr] = wrData;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int c, input int a);
    return 8'(c * 37 + a * 11 + 5);
  endfunction

  task automatic splitRead(input logic [3:0] cs, input int expCh, input int a, input bit expect_access);
    int r0;
    r0 = rdCnt;
    csN = cs; addr = 3'(a);
    waitN(3);
    rdN = 1'b0;
    waitN(5);
    if (expect_access) begin
      chk(rdCnt == r0 + 1, "R2 read pulse count", rdCnt - r0, 1);
      chk(lastRdSel == 4'(1 << expCh), "R2/R4 read channel", lastRdSel, 1 << expCh);
      chk(lastRdAddr == 3'(a), "R2 read address", lastRdAddr, a);
      chk(hostDataOe && hostDataOut == mem[expCh][a], "R2 read data", hostDataOut, mem[expCh][a]);
      waitN(6);
      chk(rdCnt == r0 + 1, "R10 one pulse while held", rdCnt - r0, 1);
    end else begin
      chk(rdCnt == r0 && !hostDataOe, "R5 no access without select", rdCnt - r0, 0);
    end
    rdN = 1'b1;
    waitN(3);
    chk(!hostDataOe, "R9 oe released", hostDataOe, 0);
    csN = 4'hF;
    waitN(3);
  endtask

  task automatic splitWrite(input int c, input int a, input logic [7:0] v);
    int w0;
    w0 = wrCnt;
    csN = ~4'(1 << c); addr = 3'(a); hostDataIn = v;
    wrN = 1'b0;
    waitN(4);
    wrN = 1'b1;
    waitN(5);
    chk(wrCnt == w0 + 1, "R3 write pulse count", wrCnt - w0, 1);
    chk(mem[c][a] == v && lastWrSel == 4'(1 << c), "R3 written byte", mem[c][a], v);
    csN = 4'hF;
    waitN(3);
  endtask

  task automatic singleRead(input int c, input int a, input logic d3);
    int r0;
    r0 = rdCnt;
    wrN = 1'b1; addr = 3'(a);
    csN = {d3, 1'(c >> 1), 1'(c), 1'b1};
    rdN = ~d3;
    waitN(3);
    csN[0] = 1'b0;
    waitN(5);
    chk(rdCnt == r0 + 1, "R6 read pulse count", rdCnt - r0, 1);
    chk(lastRdSel == 4'(1 << c), "R6/R8 read channel", lastRdSel, 1 << c);
    chk(hostDataOe && hostDataOut == mem[c][a], "R6 read data", hostDataOut, mem[c][a]);
    rdN = d3;
    waitN(3);
    chk(rdCnt == r0 + 1, "R8 rdN ignored", rdCnt - r0, 1);
    csN[0] = 1'b1;
    waitN(3);
    chk(!hostDataOe, "R9 oe released single", hostDataOe, 0);
    rdN = 1'b1;
    waitN(2);
  endtask

  task automatic singleWrite(input int c, input int a, input logic [7:0] v);
    int w0;
    w0 = wrCnt;
    addr = 3'(a); hostDataIn = v; wrN = 1'b0;
    csN = {1'(a), 1'(c >> 1), 1'(c), 1'b1};
    waitN(3);
    csN[0] = 1'b0;
    waitN(4);
    chk(wrCnt == w0, "R7 no write before select rises", wrCnt - w0, 0);
    csN[0] = 1'b1;
    waitN(5);
    chk(wrCnt == w0 + 1, "R7 write pulse count", wrCnt - w0, 1);
    chk(mem[c][a] == v && lastWrSel == 4'(1 << c), "R7 written byte", mem[c][a], v);
    wrN = 1'b1;
    waitN(3);
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 8; a++) mem[c][a] = pat(c, a);
    waitN(4);
    chk(!rdPulse && !wrPulse && !hostDataOe, "R1 reset state",
        {rdPulse, wrPulse, hostDataOe}, 0);
    rstN = 1'b1;
    waitN(3);

    // Split-strobe mode sweeps
    splitMode = 1'b1;
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 8; a++) splitRead(~4'(1 << c), c, a, 1'b1);
    for (int m = 1; m < 16; m++) begin
      int lo;
      lo = 0;
      while (!m[lo]) lo++;
      splitRead(~4'(m), lo, m % 8, 1'b1);  // R4 priority
    end
    splitRead(4'hF, 0, 0, 1'b0);
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 8; a++) splitWrite(c, a, 8'(~pat(c, a)));

    // Single-select mode sweeps
    splitMode = 1'b0;
    waitN(3);
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 8; a++) singleRead(c, a, 1'(a));
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 8; a++) singleWrite(c, a, pat(c + 5, a));

    // R8: rdN toggles with the device deselected
    begin
      int r0;
      r0 = rdCnt;
      csN = 4'hF; wrN = 1'b1;
      for (int i = 0; i < 4; i++) begin
        rdN = 1'b0; waitN(4);
        rdN = 1'b1; waitN(4);
      end
      chk(rdCnt == r0 && !hostDataOe, "R8 rdN ignored when deselected", rdCnt - r0, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule